// File: doc/BRIEF.md
# Memory Access Priority Escalator

This block decides, cycle by cycle, whether requests to each of two memory ports run at normal or at high priority. Port 0 is the control memory port and port 1 is the packet memory port. A downstream arbiter reads the result. Each port has three escalation triggers, and each trigger has its own enable bit. The triggers are a forced-high bit, a latency counter reaching a programmable threshold, and a full write buffer. The port's priority output is high while any enabled trigger is active.

Write traffic for a port arrives with a one-bit client tag: 0 for the instruction cache, 1 for the data cache. The traffic is buffered in a small first-in first-out write buffer in front of the memory request path. A per-port bypass bit takes that buffer out of the path. An error pulse can latch a lock request that halts the memory subsystem until software clears it.

Top module: `mem_prio_escalator`

## Requirements
- R1: After reset, with all configuration inputs low, every priority output and the lock output are low, both buffers report empty and not full, no memory request is raised, and both ports show wr_ready high.
- R2: A port's force bit drives that port's priority output high in the same cycle. The value of the port's other conditions makes no difference.
- R3: A port's latency count starts at 0 and adds one at every clock edge where the port's memory request is high and its grant is low. It returns to 0 on a granted edge and on any edge with no request. While the latency enable is set, the priority output is high whenever a request is pending and the count is at least the crossover threshold.
- R4: While a port's full-escalation enable is set, the priority output is high whenever that port's write buffer is full.
- R5: When a trigger's enable is cleared, its condition no longer raises the priority output. The output re-evaluates in the same cycle.
- R6: The two ports are independent. Configuration or traffic on one port never changes the other port's priority or request outputs.
- R7: With the buffer in use, the port requests memory whenever the buffer is non-empty. The head entry's data and client tag (0 for instruction cache, 1 for data cache) appear on the memory outputs. Each granted edge removes the head entry, so entries leave in the order they were written.
- R8: The buffer holds 4 entries. When 4 entries are held, full is high and wr_ready is low. A write offered while the buffer is full is dropped.
- R9: With the bypass bit set, mem_req follows wr_valid, and the memory data and tag follow the write inputs combinationally. wr_ready follows mem_gnt, and the buffer contents do not change.
- R10: An error pulse sets the lock output on the next edge when lock-on-error is enabled. With the enable low the pulse is ignored. Once set, the lock stays high until lock_clr is sampled.
- R11: If an error pulse and lock_clr arrive in the same cycle with lock-on-error enabled, the lock is set.
- R12: If a write and a grant arrive in the same cycle on a non-empty, non-full buffer, the occupancy does not change and the written entry queues behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_force_hi | input | 2 | Per port: priority always high |
| cfg_lat_esc | input | 2 | Per port: enable escalation on latency threshold |
| cfg_full_esc | input | 2 | Per port: enable escalation on full write buffer |
| cfg_wbuf_off | input | 2 | Per port: bypass the write buffer |
| cfg_xover | input | 2x8 | Per port: latency crossover threshold |
| cfg_lock_on_err | input | 1 | Error pulses latch the lock request |
| wr_valid | input | 2 | Per port: write offered by a cache client |
| wr_src | input | 2 | Per port: client tag, 0 instruction cache, 1 data cache |
| wr_data | input | 2x32 | Per port: write data |
| mem_gnt | input | 2 | Per port: arbiter grant of the memory request |
| err_pulse | input | 1 | Detected error, one cycle |
| lock_clr | input | 1 | Software clear of the lock |
| wr_ready | output | 2 | Per port: write accepted this cycle |
| mem_req | output | 2 | Per port: memory request pending |
| mem_src | output | 2 | Per port: client tag of the request |
| mem_data | output | 2x32 | Per port: data of the request |
| prio_hi | output | 2 | Per port: high priority to the arbiter |
| arb_lock | output | 1 | Halt request to the arbiter |
| wbuf_full | output | 2 | Per port: write buffer full |
| wbuf_empty | output | 2 | Per port: write buffer empty |

## Verification
Several functions can act in the same edge. A write can arrive in the same cycle as a grant on a partly filled buffer. An error pulse can arrive in the same cycle as a lock clear. The bench creates the first case by fixing occupancy at one entry and then offering a new entry while the grant is high. It judges the result by the data that appears at the head afterwards and by the empty flag once the buffer drains. It creates the second case by driving err_pulse and lock_clr on the same negative clock edge, and it expects arb_lock to be high after the next rising edge.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  // Port numbering is fixed: the arbiter decodes bit 0 as control memory.
  localparam int unsigned NPORT = 2;

  typedef enum int unsigned {
    PORT_CTRL = 0,
    PORT_PKT  = 1
  } port_e;

  typedef enum logic {
    SRC_ICACHE = 1'b0,
    SRC_DCACHE = 1'b1
  } src_e;
endpackage

// File: rtl/mpe_wbuf.sv
module mpe_wbuf #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; the write enable is the only clock enable.
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= din;
  end

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/mpe_lock.sv
module mpe_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic err,
  input  logic en,
  input  logic clr,
  output logic lock
);
  logic lock_q, lock_d;

  // Setting dominates clearing when both land in one cycle.
  always_comb begin
    lock_d = lock_q;
    if (clr)       lock_d = 1'b0;
    if (err && en) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign lock = lock_q;

  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !clr) |=> lock_q);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && en) |=> lock_q);
endmodule

// File: rtl/mpe_port.sv
module mpe_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT_W  = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_hi,
  input  logic              lat_esc,
  input  logic              full_esc,
  input  logic              wbuf_off,
  input  logic [LAT_W-1:0]  xover,
  input  logic              wr_valid,
  input  logic              wr_src,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              gnt,
  output logic              wr_ready,
  output logic              req,
  output logic              req_src,
  output logic [DATA_W-1:0] req_data,
  output logic              prio_hi,
  output logic              full,
  output logic              empty
);
  localparam int unsigned EW = DATA_W + 1;

  logic [EW-1:0]    head;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             crossed;

  mpe_wbuf #(.W(EW), .DEPTH(DEPTH)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_valid & ~wbuf_off),
    .pop   (gnt & ~wbuf_off),
    .din   ({wr_src, wr_data}),
    .dout  (head),
    .full  (full),
    .empty (empty)
  );

  assign req      = wbuf_off ? wr_valid : ~empty;
  assign req_src  = wbuf_off ? wr_src   : head[EW-1];
  assign req_data = wbuf_off ? wr_data  : head[DATA_W-1:0];
  assign wr_ready = wbuf_off ? gnt      : ~full;

  // Waiting-time counter, saturating, cleared by grant or idle.
  always_comb begin
    lat_d = lat_q;
    if (!req || gnt)      lat_d = '0;
    else if (lat_q != '1) lat_d = lat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign crossed = req & (lat_q >= xover);
  assign prio_hi = force_hi | (lat_esc & crossed) | (full_esc & full);

  p_lat_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |=> (lat_q == '0));
  p_full_escalate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_esc && full) |-> prio_hi);
  p_bypass_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_off |=> ($stable(empty) && $stable(full)));
endmodule

// File: rtl/mem_prio_escalator.sv
module mem_prio_escalator
  import mpe_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT_W  = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             cfg_force_hi,
  input  logic [NPORT-1:0]             cfg_lat_esc,
  input  logic [NPORT-1:0]             cfg_full_esc,
  input  logic [NPORT-1:0]             cfg_wbuf_off,
  input  logic [NPORT-1:0][LAT_W-1:0]  cfg_xover,
  input  logic                         cfg_lock_on_err,
  input  logic [NPORT-1:0]             wr_valid,
  input  logic [NPORT-1:0]             wr_src,
  input  logic [NPORT-1:0][DATA_W-1:0] wr_data,
  input  logic [NPORT-1:0]             mem_gnt,
  input  logic                         err_pulse,
  input  logic                         lock_clr,
  output logic [NPORT-1:0]             wr_ready,
  output logic [NPORT-1:0]             mem_req,
  output logic [NPORT-1:0]             mem_src,
  output logic [NPORT-1:0][DATA_W-1:0] mem_data,
  output logic [NPORT-1:0]             prio_hi,
  output logic                         arb_lock,
  output logic [NPORT-1:0]             wbuf_full,
  output logic [NPORT-1:0]             wbuf_empty
);
  // rst_n is expected to leave the reset tree already synchronised to clk.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mpe_port #(.DATA_W(DATA_W), .LAT_W(LAT_W), .DEPTH(DEPTH)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_hi (cfg_force_hi[p]),
      .lat_esc  (cfg_lat_esc[p]),
      .full_esc (cfg_full_esc[p]),
      .wbuf_off (cfg_wbuf_off[p]),
      .xover    (cfg_xover[p]),
      .wr_valid (wr_valid[p]),
      .wr_src   (wr_src[p]),
      .wr_data  (wr_data[p]),
      .gnt      (mem_gnt[p]),
      .wr_ready (wr_ready[p]),
      .req      (mem_req[p]),
      .req_src  (mem_src[p]),
      .req_data (mem_data[p]),
      .prio_hi  (prio_hi[p]),
      .full     (wbuf_full[p]),
      .empty    (wbuf_empty[p])
    );
  end

  mpe_lock u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .err   (err_pulse),
    .en    (cfg_lock_on_err),
    .clr   (lock_clr),
    .lock  (arb_lock)
  );
endmodule

// File: tb/test_mem_prio_escalator.sv
module test_mem_prio_escalator;
  localparam int DW = 32;
  localparam int LW = 8;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [1:0]          cfg_force_hi, cfg_lat_esc, cfg_full_esc, cfg_wbuf_off;
  logic [1:0][LW-1:0]  cfg_xover;
  logic                cfg_lock_on_err;
  logic [1:0]          wr_valid, wr_src, mem_gnt;
  logic [1:0][DW-1:0]  wr_data;
  logic                err_pulse, lock_clr;
  logic [1:0]          wr_ready, mem_req, mem_src, prio_hi, wbuf_full, wbuf_empty;
  logic [1:0][DW-1:0]  mem_data;
  logic                arb_lock;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  mem_prio_escalator i_mem_prio_escalator (
    .clk(clk), .rst_n(rst_n),
    .cfg_force_hi(cfg_force_hi), .cfg_lat_esc(cfg_lat_esc),
    .cfg_full_esc(cfg_full_esc), .cfg_wbuf_off(cfg_wbuf_off),
    .cfg_xover(cfg_xover), .cfg_lock_on_err(cfg_lock_on_err),
    .wr_valid(wr_valid), .wr_src(wr_src), .wr_data(wr_data),
    .mem_gnt(mem_gnt), .err_pulse(err_pulse), .lock_clr(lock_clr),
    .wr_ready(wr_ready), .mem_req(mem_req), .mem_src(mem_src),
    .mem_data(mem_data), .prio_hi(prio_hi), .arb_lock(arb_lock),
    .wbuf_full(wbuf_full), .wbuf_empty(wbuf_empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change just after the falling edge; #1 lets combinational paths settle.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check("R1 prio_hi", 64'(prio_hi), 64'd0);
    check("R1 arb_lock", 64'(arb_lock), 64'd0);
    check("R1 empty", 64'(wbuf_empty), 64'd3);
    check("R1 full", 64'(wbuf_full), 64'd0);
    check("R1 mem_req", 64'(mem_req), 64'd0);
    check("R1 wr_ready", 64'(wr_ready), 64'd3);
  endtask

  task automatic t_force();
    step(); cfg_force_hi = 2'b01; #1;
    check("R2 force port0", 64'(prio_hi), 64'd1);
    check("R6 port1 untouched", 64'(prio_hi[1]), 64'd0);
    cfg_force_hi = 2'b11; #1;
    check("R2 force both", 64'(prio_hi), 64'd3);
    cfg_force_hi = 2'b00; #1;
    check("R5 force removed", 64'(prio_hi), 64'd0);
  endtask

  task automatic t_latency();
    step();
    cfg_wbuf_off[0] = 1'b1; cfg_lat_esc[0] = 1'b1; cfg_xover[0] = 8'd3;
    wr_valid[0] = 1'b1; wr_src[0] = 1'b1; wr_data[0] = 32'hCAFE_0001;
    #1;
    check("R9 bypass request", 64'(mem_req[0]), 64'd1);
    check("R9 bypass data", 64'(mem_data[0]), 64'hCAFE_0001);
    check("R9 bypass tag", 64'(mem_src[0]), 64'd1);
    check("R9 ready follows grant", 64'(wr_ready[0]), 64'd0);
    step(); step();
    check("R3 below threshold", 64'(prio_hi[0]), 64'd0);
    step();
    check("R3 threshold reached", 64'(prio_hi[0]), 64'd1);
    check("R6 port1 stays low", 64'(prio_hi[1] | mem_req[1]), 64'd0);
    cfg_lat_esc[0] = 1'b0; #1;
    check("R5 latency enable off", 64'(prio_hi[0]), 64'd0);
    cfg_lat_esc[0] = 1'b1; mem_gnt[0] = 1'b1; #1;
    check("R9 ready with grant", 64'(wr_ready[0]), 64'd1);
    step();
    mem_gnt[0] = 1'b0; #1;
    check("R3 cleared by grant", 64'(prio_hi[0]), 64'd0);
    wr_valid[0] = 1'b0; #1;
    check("R9 buffer untouched", 64'(wbuf_empty[0]), 64'd1);
    check("R9 request follows valid", 64'(mem_req[0]), 64'd0);
    cfg_wbuf_off[0] = 1'b0; cfg_lat_esc[0] = 1'b0;
  endtask

  task automatic t_full();
    cfg_full_esc[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(); wr_valid[1] = 1'b1; wr_data[1] = 32'h100 + i; wr_src[1] = i[0];
    end
    step(); wr_valid[1] = 1'b0; #1;
    check("R8 full after 4", 64'(wbuf_full[1]), 64'd1);
    check("R8 ready low when full", 64'(wr_ready[1]), 64'd0);
    check("R4 full escalates", 64'(prio_hi[1]), 64'd1);
    check("R7 request when non-empty", 64'(mem_req[1]), 64'd1);
    check("R6 port0 low", 64'(prio_hi[0]), 64'd0);
    cfg_full_esc[1] = 1'b0; #1;
    check("R5 full enable off", 64'(prio_hi[1]), 64'd0);
    cfg_full_esc[1] = 1'b1;
    wr_valid[1] = 1'b1; wr_data[1] = 32'hBAD; wr_src[1] = 1'b1;
    step(); wr_valid[1] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R7 head data", 64'(mem_data[1]), 64'h100 + 64'(i));
      check("R7 head tag", 64'(mem_src[1]), 64'(i % 2));
      if (i == 1) check("R4 drops after pop", 64'(prio_hi[1]), 64'd0);
      mem_gnt[1] = 1'b1;
      step();
    end
    mem_gnt[1] = 1'b0; #1;
    check("R8 write while full dropped", 64'(wbuf_empty[1]), 64'd1);
    check("R7 no request when empty", 64'(mem_req[1]), 64'd0);
    cfg_full_esc[1] = 1'b0;
  endtask

  task automatic t_concurrent();
    step(); wr_valid[1] = 1'b1; wr_data[1] = 32'hAAAA; wr_src[1] = 1'b0;
    step(); wr_data[1] = 32'hBBBB; wr_src[1] = 1'b1; mem_gnt[1] = 1'b1; #1;
    check("R12 head before", 64'(mem_data[1]), 64'hAAAA);
    step(); wr_valid[1] = 1'b0; mem_gnt[1] = 1'b0; #1;
    check("R12 new entry at head", 64'(mem_data[1]), 64'hBBBB);
    check("R12 tag at head", 64'(mem_src[1]), 64'd1);
    mem_gnt[1] = 1'b1;
    step(); mem_gnt[1] = 1'b0; #1;
    check("R12 occupancy kept at one", 64'(wbuf_empty[1]), 64'd1);
  endtask

  task automatic t_lock();
    step(); err_pulse = 1'b1;
    step(); err_pulse = 1'b0; #1;
    check("R10 ignored when disabled", 64'(arb_lock), 64'd0);
    cfg_lock_on_err = 1'b1; err_pulse = 1'b1;
    step(); err_pulse = 1'b0; #1;
    check("R10 lock set", 64'(arb_lock), 64'd1);
    step(); step(); #1;
    check("R10 lock held", 64'(arb_lock), 64'd1);
    lock_clr = 1'b1;
    step(); lock_clr = 1'b0; #1;
    check("R10 lock cleared", 64'(arb_lock), 64'd0);
    err_pulse = 1'b1; lock_clr = 1'b1;
    step(); err_pulse = 1'b0; lock_clr = 1'b0; #1;
    check("R11 set beats clear", 64'(arb_lock), 64'd1);
    lock_clr = 1'b1;
    step(); lock_clr = 1'b0; #1;
    check("R10 cleared again", 64'(arb_lock), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_force_hi = '0; cfg_lat_esc = '0; cfg_full_esc = '0; cfg_wbuf_off = '0;
    cfg_xover = '0; cfg_lock_on_err = 1'b0;
    wr_valid = '0; wr_src = '0; wr_data = '0; mem_gnt = '0;
    err_pulse = 1'b0; lock_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_force();
    t_latency();
    t_full();
    t_concurrent();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule